// File: doc/BRIEF.md
# Edge/Level Interrupt Pending Controller

This block gathers 64 interrupt request lines and keeps five bits of state for each line: a trigger-mode select (edge or level), a mask, a pending request, an in-service flag and the level last seen on the line. Every line also has an 8-bit vector that chooses one of 256 parent interrupt outputs. When an event arrives, the block runs a single evaluation that picks the lowest-numbered eligible line. It then moves that line into service or out of service and drives high or low the parent output that the line's vector names.

Events arrive on one event port, at most one per clock cycle, and are handled in the order they come. Each event is one of the following: a level change on a line, a masked write to the mask bits, a masked write to the trigger-mode bits, a clear of edge-mode requests, or a write to one line's vector. A register interface that sits in front of this block produces these events. The parent outputs are registered, so each output moves on the clock edge that consumes the event.

Top module: `edge_level_pic`

## Requirements
- R1: For an edge-mode line, a line event with level 1 sets the pending bit only if the last seen level of that line was 0. A second high event while the last level is already 1 adds no new request.
- R2: For an edge-mode line, a line event with level 0 only records the new last level. The pending bit stays set, and the parent output that the line drives stays high.
- R3: For a level-mode line, the pending bit and the last level both take the value of the event's level. A low event on an in-service line that is now not pending lowers its output.
- R4: A line event with level 1 makes the line in service if it is pending and unmasked. The parent output indexed by its vector goes high on the next clock edge.
- R5: A line event with level 0 takes the line out of service if it is in service and no longer pending. The parent output its vector selects goes low on the next clock edge.
- R6: A mask write that unmasks several pending lines at once puts only the lowest-numbered of them into service and raises only that line's output.
- R7: A mask write that masks lines releases only the lowest-numbered newly masked line that is in service and not pending. Masking a line that is still pending leaves its output unchanged.
- R8: A clear write acts only on the data bits of edge-mode lines. It clears their pending bits, lowers the output of the lowest-numbered one that was in service, and takes all of them out of service. Level-mode lines are unaffected.
- R9: Each line has its own 8-bit vector, set by a vector write that takes the line number and data bits 7:0. Lines that share a vector share an output, and the most recent raise or lower of that output wins.
- R10: While reset is high, all state bits and vectors go to 0, so every line is level mode and unmasked, and every parent output is low.
- R11: The op encoding is 0 idle, 1 line event, 2 mask write, 3 trigger-mode write, 4 clear, 5 vector write. Mask and trigger-mode writes store (old & ~wmask) | (wdata & wmask), so a zero write mask leaves everything unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_op | input | 3 | Event code, encoded as in R11 |
| ev_line | input | 6 | Line number for line events and vector writes |
| ev_level | input | 1 | New input level for a line event |
| ev_wdata | input | 64 | Write data: mask, mode or clear bits, or vector value in bits 7:0 |
| ev_wmask | input | 64 | Per-bit write enable for mask and trigger-mode writes |
| parent_out | output | 256 | Parent interrupt outputs |

## Verification
The assertions assume at most one event in each cycle, that the event fields are valid only in the cycle they are presented, and that reset is high at the first clock edge. They also assume the op code is one of the six defined values. The stimulus follows these rules by applying one event per clock and returning to idle between events. Its random op codes come only from the defined set. Line numbers and vector values are drawn mostly from small ranges, so that lines share vectors and one event often meets several eligible candidates at once.

// File: rtl/edge_level_pic_pkg.sv
package edge_level_pic_pkg;

    localparam int NUM_LINES = 64;
    localparam int VEC_W     = 8;
    localparam int NUM_OUTS  = 1 << VEC_W;
    localparam int LINE_W    = $clog2(NUM_LINES);

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_LINE  = 3'd1,
        OP_MASK  = 3'd2,
        OP_EDGE  = 3'd3,
        OP_CLEAR = 3'd4,
        OP_VEC   = 3'd5
    } ev_op_e;

    typedef struct packed {
        logic [NUM_LINES-1:0] pend;
        logic [NUM_LINES-1:0] last;
        logic [NUM_LINES-1:0] isr;
        logic [NUM_LINES-1:0] mask;
        logic [NUM_LINES-1:0] edge_md;
    } line_state_t;

    function automatic logic [NUM_LINES-1:0] merge_bits(
        input logic [NUM_LINES-1:0] old_v,
        input logic [NUM_LINES-1:0] wdata,
        input logic [NUM_LINES-1:0] wmask);
        return (old_v & ~wmask) | (wdata & wmask);
    endfunction

endpackage

// File: rtl/epic_lowest_pick.sv
module epic_lowest_pick #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     cand,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (cand[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/epic_vec_table.sv
module epic_vec_table #(
    parameter int LINES  = 64,
    parameter int VEC_W  = 8,
    parameter int LINE_W = $clog2(LINES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [VEC_W-1:0]  wr_vec,
    input  logic [LINE_W-1:0] rd_a_line,
    output logic [VEC_W-1:0]  rd_a_vec,
    input  logic [LINE_W-1:0] rd_b_line,
    output logic [VEC_W-1:0]  rd_b_vec
);
    logic [VEC_W-1:0] vec_q [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                vec_q[g] <= '0;
            end else if (wr_en && (wr_line == LINE_W'(g))) begin
                vec_q[g] <= wr_vec;
            end
        end
    end

    assign rd_a_vec = vec_q[rd_a_line];
    assign rd_b_vec = vec_q[rd_b_line];
endmodule

// File: rtl/epic_out_bank.sv
module epic_out_bank #(
    parameter int VEC_W = 8,
    parameter int OUTS  = 1 << VEC_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             set_en,
    input  logic [VEC_W-1:0] set_idx,
    input  logic             clr_en,
    input  logic [VEC_W-1:0] clr_idx,
    output logic [OUTS-1:0]  out_q
);
    for (genvar g = 0; g < OUTS; g++) begin : g_out
        always_ff @(posedge clk) begin
            if (rst) begin
                out_q[g] <= 1'b0;
            end else if (clr_en && (clr_idx == VEC_W'(g))) begin
                out_q[g] <= 1'b0;   // lowering is evaluated after raising
            end else if (set_en && (set_idx == VEC_W'(g))) begin
                out_q[g] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/edge_level_pic.sv
module edge_level_pic
    import edge_level_pic_pkg::*;
#(
    parameter int LINES  = NUM_LINES,
    parameter int VW     = VEC_W,
    parameter int OUTS   = 1 << VW,
    parameter int LW     = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [2:0]       ev_op,
    input  logic [LW-1:0]    ev_line,
    input  logic             ev_level,
    input  logic [LINES-1:0] ev_wdata,
    input  logic [LINES-1:0] ev_wmask,
    output logic [OUTS-1:0]  parent_out
);
    ev_op_e op;
    assign op = ev_op_e'(ev_op);

    logic [LINES-1:0] pend_q, last_q, isr_q, mask_q, edge_q;
    logic [LINES-1:0] pend_n, last_n, isr_n, mask_n, edge_n;
    logic [LINES-1:0] rise_cand, fall_cand, drop_set, line_sel;
    logic             rise_hit, fall_hit, vec_we;
    logic [LW-1:0]    rise_idx, fall_idx;
    logic [VW-1:0]    rise_vec, fall_vec;

    // next-state of per-line bits and candidate sets for this event
    always_comb begin
        pend_n    = pend_q;
        last_n    = last_q;
        mask_n    = mask_q;
        edge_n    = edge_q;
        rise_cand = '0;
        fall_cand = '0;
        drop_set  = '0;
        vec_we    = 1'b0;
        line_sel  = LINES'(1) << ev_line;
        case (op)
            OP_LINE: begin
                if (edge_q[ev_line]) begin
                    if (ev_level && !last_q[ev_line]) begin
                        pend_n[ev_line] = 1'b1;
                    end
                end else begin
                    pend_n[ev_line] = ev_level;
                end
                last_n[ev_line] = ev_level;
                if (ev_level) begin
                    rise_cand = line_sel & pend_n & ~mask_q;
                end else begin
                    fall_cand = line_sel & isr_q & ~pend_n;
                end
            end
            OP_MASK: begin
                mask_n    = merge_bits(mask_q, ev_wdata, ev_wmask);
                rise_cand = mask_q & ~mask_n & pend_q;
                fall_cand = ~mask_q & mask_n & isr_q & ~pend_q;
            end
            OP_EDGE: begin
                edge_n = merge_bits(edge_q, ev_wdata, ev_wmask);
            end
            OP_CLEAR: begin
                drop_set  = ev_wdata & edge_q;
                pend_n    = pend_q & ~drop_set;
                fall_cand = drop_set & isr_q & ~pend_n;
            end
            OP_VEC: begin
                vec_we = 1'b1;
            end
            default: begin
            end
        endcase
    end

    epic_lowest_pick #(.N(LINES), .IDX_W(LW)) u_rise_pick (
        .cand  (rise_cand),
        .found (rise_hit),
        .idx   (rise_idx)
    );

    epic_lowest_pick #(.N(LINES), .IDX_W(LW)) u_fall_pick (
        .cand  (fall_cand),
        .found (fall_hit),
        .idx   (fall_idx)
    );

    epic_vec_table #(.LINES(LINES), .VEC_W(VW), .LINE_W(LW)) u_vec (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (vec_we),
        .wr_line   (ev_line),
        .wr_vec    (ev_wdata[VW-1:0]),
        .rd_a_line (rise_idx),
        .rd_a_vec  (rise_vec),
        .rd_b_line (fall_idx),
        .rd_b_vec  (fall_vec)
    );

    epic_out_bank #(.VEC_W(VW), .OUTS(OUTS)) u_out (
        .clk     (clk),
        .rst     (rst),
        .set_en  (rise_hit),
        .set_idx (rise_vec),
        .clr_en  (fall_hit),
        .clr_idx (fall_vec),
        .out_q   (parent_out)
    );

    always_comb begin
        isr_n = isr_q;
        if (rise_hit) begin
            isr_n = isr_n | (LINES'(1) << rise_idx);
        end
        if (fall_hit) begin
            isr_n = isr_n & ~(LINES'(1) << fall_idx);
        end
        isr_n = isr_n & ~drop_set;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            last_q <= '0;
            isr_q  <= '0;
            mask_q <= '0;
            edge_q <= '0;
        end else begin
            pend_q <= pend_n;
            last_q <= last_n;
            isr_q  <= isr_n;
            mask_q <= mask_n;
            edge_q <= edge_n;
        end
    end

    // ---------------- assertions ----------------
    a_r1_edge_rise_pends: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LINE) && edge_q[ev_line] && ev_level && !last_q[ev_line]
        |=> pend_q[$past(ev_line)]);

    a_r2_edge_fall_keeps: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LINE) && edge_q[ev_line] && !ev_level && pend_q[ev_line]
        |=> pend_q[$past(ev_line)] && !last_q[$past(ev_line)]);

    a_r3_level_follows: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LINE) && !edge_q[ev_line]
        |=> pend_q[$past(ev_line)] == $past(ev_level));

    a_r4_level_high_serves: assert property (@(posedge clk) disable iff (rst)
        (op == OP_LINE) && ev_level && !edge_q[ev_line] && !mask_q[ev_line]
        |=> isr_q[$past(ev_line)] && parent_out[$past(rise_vec)]);

    a_r6_one_entry: assert property (@(posedge clk) disable iff (rst)
        (op != OP_IDLE) |=> ($countones(isr_q & ~$past(isr_q)) <= 1));

    a_r8_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (op == OP_CLEAR) |=> ((isr_q & $past(ev_wdata & edge_q)) == '0));

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> (parent_out == '0));

endmodule

// File: tb/edge_level_pic_test.sv
module edge_level_pic_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [2:0]   ev_op = 3'd0;
    logic [5:0]   ev_line = '0;
    logic         ev_level = 1'b0;
    logic [63:0]  ev_wdata = '0;
    logic [63:0]  ev_wmask = '0;
    logic [255:0] parent_out;

    int n_checks = 0;
    int n_fail   = 0;

    // reference state
    logic [63:0]  m_pend, m_last, m_isr, m_mask, m_edge;
    logic [7:0]   m_vec [64];
    logic [255:0] m_out;

    always #2 clk = ~clk;

    edge_level_pic uut (
        .clk        (clk),
        .rst        (rst),
        .ev_op      (ev_op),
        .ev_line    (ev_line),
        .ev_level   (ev_level),
        .ev_wdata   (ev_wdata),
        .ev_wmask   (ev_wmask),
        .parent_out (parent_out)
    );

    function automatic int lowest(input logic [63:0] v);
        for (int i = 0; i < 64; i++) begin
            if (v[i]) return i;
        end
        return -1;
    endfunction

    task automatic model_reset();
        m_pend = '0; m_last = '0; m_isr = '0; m_mask = '0; m_edge = '0;
        m_out  = '0;
        for (int i = 0; i < 64; i++) m_vec[i] = '0;
    endtask

    task automatic model_apply(input logic [2:0] op, input int ln, input logic lvl,
                               input logic [63:0] wd, input logic [63:0] wm);
        logic [63:0] pn, up, dn, drop, nm;
        int a, d;
        pn = m_pend; up = '0; dn = '0; drop = '0;
        case (op)
            3'd1: begin
                if (m_edge[ln]) begin
                    if (lvl && !m_last[ln]) pn[ln] = 1'b1;
                end else begin
                    pn[ln] = lvl;
                end
                m_last[ln] = lvl;
                if (lvl) up[ln] = pn[ln] & ~m_mask[ln];
                else     dn[ln] = m_isr[ln] & ~pn[ln];
            end
            3'd2: begin
                nm = (m_mask & ~wm) | (wd & wm);
                up = m_mask & ~nm & m_pend;
                dn = ~m_mask & nm & m_isr & ~m_pend;
                m_mask = nm;
            end
            3'd3: m_edge = (m_edge & ~wm) | (wd & wm);
            3'd4: begin
                drop = wd & m_edge;
                pn   = m_pend & ~drop;
                dn   = drop & m_isr & ~pn;
            end
            3'd5: m_vec[ln] = wd[7:0];
            default: ;
        endcase
        a = lowest(up);
        d = lowest(dn);
        if (a >= 0) begin m_isr[a] = 1'b1; m_out[m_vec[a]] = 1'b1; end
        if (d >= 0) begin m_isr[d] = 1'b0; m_out[m_vec[d]] = 1'b0; end
        m_isr  = m_isr & ~drop;
        m_pend = pn;
    endtask

    task automatic check_all(input string req);
        n_checks++;
        if (parent_out !== m_out) begin
            n_fail++;
            $display("FAIL %s: parent_out=%h expected=%h", req, parent_out, m_out);
        end
    endtask

    task automatic check_bit(input string req, input int idx, input logic exp);
        n_checks++;
        if (parent_out[idx] !== exp) begin
            n_fail++;
            $display("FAIL %s: parent_out[%0d]=%b expected=%b", req, idx, parent_out[idx], exp);
        end
    endtask

    task automatic step(input logic [2:0] op, input int ln, input logic lvl,
                        input logic [63:0] wd, input logic [63:0] wm, input string req);
        @(negedge clk);
        ev_op = op; ev_line = ln[5:0]; ev_level = lvl; ev_wdata = wd; ev_wmask = wm;
        model_apply(op, ln, lvl, wd, wm);
        @(posedge clk);
        #1;
        ev_op = 3'd0;
        check_all(req);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; ev_op = 3'd0;
        repeat (3) @(posedge clk);
        #1;
        model_reset();
        @(negedge clk);
        rst = 1'b0;
    endtask

    function automatic logic [63:0] bit64(input int i);
        return 64'd1 << i;
    endfunction

    initial begin
        void'($urandom(32'd4711));
        model_reset();
        do_reset();
        check_all("R10 reset");

        // R9: vector selects output; R4 level high raises it
        step(3'd5, 3, 1'b0, 64'd200, '0, "R9");
        step(3'd1, 3, 1'b1, '0, '0, "R4");
        check_bit("R4", 200, 1'b1);
        step(3'd1, 3, 1'b0, '0, '0, "R3");
        check_bit("R3 R5", 200, 1'b0);

        // edge line 5 on vector 7 (R11 op 3 masked write)
        step(3'd3, 0, 1'b0, bit64(5) | bit64(6), bit64(5), "R11");
        step(3'd5, 5, 1'b0, 64'd7, '0, "R9");
        step(3'd1, 5, 1'b1, '0, '0, "R1");
        check_bit("R1", 7, 1'b1);
        step(3'd1, 5, 1'b0, '0, '0, "R2");
        check_bit("R2", 7, 1'b1);
        step(3'd4, 0, 1'b0, bit64(5), '0, "R8");
        check_bit("R8", 7, 1'b0);
        step(3'd1, 5, 1'b1, '0, '0, "R1");
        step(3'd1, 5, 1'b1, '0, '0, "R1");
        check_bit("R1 no repeat", 7, 1'b1);
        step(3'd4, 0, 1'b0, bit64(5), '0, "R8");
        step(3'd1, 5, 1'b1, '0, '0, "R1");
        check_bit("R1 still high level", 7, 1'b0);

        // clear ignores a level-mode line
        step(3'd1, 3, 1'b1, '0, '0, "R4");
        step(3'd4, 0, 1'b0, bit64(3), '0, "R8");
        check_bit("R8 level ignored", 200, 1'b1);
        step(3'd1, 3, 1'b0, '0, '0, "R5");
        check_bit("R5", 200, 1'b0);

        // mask ordering on edge lines 10 and 12
        step(3'd3, 0, 1'b0, bit64(10) | bit64(12), bit64(10) | bit64(12), "R11");
        step(3'd5, 10, 1'b0, 64'd20, '0, "R9");
        step(3'd5, 12, 1'b0, 64'd22, '0, "R9");
        step(3'd2, 0, 1'b0, bit64(10) | bit64(12), bit64(10) | bit64(12), "R11");
        step(3'd1, 10, 1'b1, '0, '0, "R6");
        step(3'd1, 12, 1'b1, '0, '0, "R6");
        check_bit("R6 masked", 20, 1'b0);
        step(3'd2, 0, 1'b0, '1, '0, "R11 zero wmask");
        check_bit("R11 zero wmask", 20, 1'b0);
        step(3'd2, 0, 1'b0, '0, bit64(10) | bit64(12), "R6");
        check_bit("R6 lowest", 20, 1'b1);
        check_bit("R6 higher waits", 22, 1'b0);
        step(3'd2, 0, 1'b0, bit64(12), bit64(12), "R7");
        step(3'd2, 0, 1'b0, '0, bit64(12), "R6");
        check_bit("R6 single", 22, 1'b1);
        step(3'd2, 0, 1'b0, bit64(10), bit64(10), "R7");
        check_bit("R7 pending kept", 20, 1'b1);
        step(3'd4, 0, 1'b0, bit64(10) | bit64(12), '0, "R8");
        check_bit("R8 lowest lowered", 20, 1'b0);
        check_bit("R8 other kept", 22, 1'b1);
        step(3'd2, 0, 1'b0, '0, bit64(10), "R6");

        // shared vector
        step(3'd5, 20, 1'b0, 64'd40, '0, "R9");
        step(3'd5, 21, 1'b0, 64'd40, '0, "R9");
        step(3'd1, 20, 1'b1, '0, '0, "R9");
        step(3'd1, 21, 1'b1, '0, '0, "R9");
        step(3'd1, 20, 1'b0, '0, '0, "R9");
        check_bit("R9 shared last wins", 40, 1'b0);

        do_reset();
        check_all("R10 second reset");

        // constrained random
        for (int k = 0; k < 4000; k++) begin
            int r, ln;
            logic [63:0] wd, wm;
            r  = int'($urandom % 16);
            ln = (($urandom % 4) == 0) ? int'($urandom % 64) : int'($urandom % 8);
            wd = {$urandom, $urandom};
            wm = {$urandom, $urandom};
            if (($urandom % 2) == 0) begin
                wd = wd & 64'hFF;
                wm = wm & 64'hFF;
            end
            if (r < 9)       step(3'd1, ln, $urandom % 2 == 1, '0, '0, "random line");
            else if (r < 11) step(3'd2, ln, 1'b0, wd, wm, "random mask");
            else if (r < 12) step(3'd3, ln, 1'b0, wd, wm, "random mode");
            else if (r < 13) step(3'd4, ln, 1'b0, wd, '0, "random clear");
            else if (r < 14) step(3'd5, ln, 1'b0, 64'($urandom % 16), '0, "random vector");
            else             step(3'd0, ln, 1'b0, '0, '0, "random idle");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule